// File: doc/BRIEF.md
# Threshold Offset Programming Controller

This block holds the two threshold values that a FIFO's flag logic uses to decide when the buffer counts as nearly empty or nearly full. Each threshold is an offset register loaded from the low bits of the FIFO's write data bus. One configuration strobe, combined with the ordinary write enable, steps through the two registers in a fixed, wrapping order: almost-empty, then almost-full, then almost-empty again. The position in that order is kept when the strobe drops, so a later programming session carries on where the last one stopped.

Readback works in the same way on the read side. The configuration strobe together with the read enable places the selected register on the output bus at a read-clock edge. The unused upper bits read as zero. The read side has its own selection pointer, which is clocked by the read clock. While the strobe is high, the FIFO's normal data write and read enables are masked, so no data word is stored or consumed during programming. Reset restores both offsets to a default value and points both selectors back at the almost-empty register.

Top module: `ofs_loader`

## Requirements
- R1: After reset, `ae_offset` and `af_offset` both equal `OFS_DEFAULT`, and `rd_data` is zero.
- R2: The first write-clock edge with `cfg_en` and `wr_en` both high after reset stores `wr_data[OFS_W-1:0]` into `ae_offset`.
- R3: Successive configuration writes alternate between registers: the second goes to `af_offset`, the third goes to `ae_offset` again, and so on. Exactly one register changes per write.
- R4: Without both `cfg_en` and `wr_en` high at a write-clock edge, neither offset changes. This covers `cfg_en` alone and a plain data write (`wr_en` alone).
- R5: The write selector holds its position across sessions. After `cfg_en` falls and rises again, the next configuration write goes to the register that follows the last one written.
- R6: At each read-clock edge with `cfg_en` and `rd_en` both high, `rd_data` takes the selected offset, zero-extended to `DATA_W`. The selection alternates starting from almost-empty. At other edges `rd_data` holds its value.
- R7: The read selector advances only on readback cycles and is independent of how many configuration writes have occurred.
- R8: `fifo_wr_ok` is high only when `wr_en` is high and `cfg_en` is low. `fifo_rd_ok` is high only when `rd_en` is high and `cfg_en` is low.
- R9: A reset in the middle of a sequence returns both selectors to the almost-empty register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| cfg_en | input | 1 | Configuration strobe; steers enables to the offset registers |
| wr_en | input | 1 | Write enable shared with the FIFO data path |
| rd_en | input | 1 | Read enable shared with the FIFO data path |
| wr_data | input | DATA_W | Write data bus; low OFS_W bits load an offset |
| rd_data | output | DATA_W | Readback bus, zero-extended offset |
| ae_offset | output | OFS_W | Almost-empty threshold to the flag logic |
| af_offset | output | OFS_W | Almost-full threshold to the flag logic |
| fifo_wr_ok | output | 1 | Data write enable passed on to the FIFO storage |
| fifo_rd_ok | output | 1 | Data read enable passed on to the FIFO storage |

## Verification
The bench builds the block with `DATA_W` = 18, `OFS_W` = 6 and `OFS_DEFAULT` = 45. The narrow offset means the stimulus words carry set bits above the offset field, which shows that the high bits are truncated on writes and returned as zero on readback. The non-power-of-two default cannot be mistaken for an all-ones or an all-zeros reset value. The two clocks have periods of 10 and 14 units, so the write and read selectors advance at different rates, and the bench shows that they never share a position by accident.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;

    function automatic ofs_sel_e sel_after(ofs_sel_e cur);
        return (cur == SEL_AE) ? SEL_AF : SEL_AE;
    endfunction

endpackage

// File: rtl/ofs_sel_ptr.sv
module ofs_sel_ptr
    import ofs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     step,
    output ofs_sel_e sel
);

    ofs_sel_e sel_q;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= SEL_AE;
        else if (step)
            sel_q <= sel_after(sel_q);
    end

    assign sel = sel_q;

endmodule

// File: rtl/ofs_store.sv
module ofs_store
    import ofs_pkg::*;
#(
    parameter int OFS_W       = 14,
    parameter int OFS_DEFAULT = 127
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  ofs_sel_e         sel,
    input  logic [OFS_W-1:0] din,
    output logic [OFS_W-1:0] ae,
    output logic [OFS_W-1:0] af
);

    localparam int NREG = 2;
    localparam logic [OFS_W-1:0] DEF_VAL = OFS_W'(OFS_DEFAULT);

    logic [NREG-1:0][OFS_W-1:0] regs_q;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst)
                regs_q[i] <= DEF_VAL;
            else if (we && (int'(sel) == i))
                regs_q[i] <= din;
        end
    end

    assign ae = regs_q[int'(SEL_AE)];
    assign af = regs_q[int'(SEL_AF)];

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
    import ofs_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int OFS_W  = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              re,
    input  ofs_sel_e          sel,
    input  logic [OFS_W-1:0]  ae,
    input  logic [OFS_W-1:0]  af,
    output logic [DATA_W-1:0] rdata
);

    logic [OFS_W-1:0]  pick;
    logic [DATA_W-1:0] rdata_q;

    always_comb pick = (sel == SEL_AE) ? ae : af;

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (re)
            rdata_q <= DATA_W'(pick);
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
    import ofs_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int OFS_W       = 14,
    parameter int OFS_DEFAULT = 127
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [OFS_W-1:0]  ae_offset,
    output logic [OFS_W-1:0]  af_offset,
    output logic              fifo_wr_ok,
    output logic              fifo_rd_ok
);

    logic     cfg_wr;
    logic     cfg_rd;
    ofs_sel_e wr_sel;
    ofs_sel_e rd_sel;
    logic     unused_hi;

    assign cfg_wr     = cfg_en & wr_en;
    assign cfg_rd     = cfg_en & rd_en;
    assign fifo_wr_ok = wr_en & ~cfg_en;
    assign fifo_rd_ok = rd_en & ~cfg_en;
    assign unused_hi  = ^wr_data[DATA_W-1:OFS_W];

    ofs_sel_ptr wsel_i (
        .clk  (wclk),
        .rst  (rst),
        .step (cfg_wr),
        .sel  (wr_sel)
    );

    ofs_sel_ptr rsel_i (
        .clk  (rclk),
        .rst  (rst),
        .step (cfg_rd),
        .sel  (rd_sel)
    );

    ofs_store #(
        .OFS_W       (OFS_W),
        .OFS_DEFAULT (OFS_DEFAULT)
    ) store_i (
        .clk (wclk),
        .rst (rst),
        .we  (cfg_wr),
        .sel (wr_sel),
        .din (wr_data[OFS_W-1:0]),
        .ae  (ae_offset),
        .af  (af_offset)
    );

    ofs_readback #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) rback_i (
        .clk   (rclk),
        .rst   (rst),
        .re    (cfg_rd),
        .sel   (rd_sel),
        .ae    (ae_offset),
        .af    (af_offset),
        .rdata (rd_data)
    );

endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk
    import ofs_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int OFS_W       = 14,
    parameter int OFS_DEFAULT = 127
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst,
    input logic              cfg_en,
    input logic              wr_en,
    input logic              rd_en,
    input logic [OFS_W-1:0]  wr_low,
    input logic [DATA_W-1:0] rd_data,
    input logic [OFS_W-1:0]  ae_offset,
    input logic [OFS_W-1:0]  af_offset,
    input ofs_sel_e          wr_sel,
    input ofs_sel_e          rd_sel
);

    // R1
    reset_default_chk: assert property (@(posedge wclk) disable iff (rst)
        $fell(rst) |-> (ae_offset == OFS_W'(OFS_DEFAULT)) && (af_offset == OFS_W'(OFS_DEFAULT)));

    // R2
    ae_load_chk: assert property (@(posedge wclk) disable iff (rst)
        (cfg_en && wr_en && wr_sel == SEL_AE) |=> (ae_offset == $past(wr_low)) && $stable(af_offset));

    // R3
    af_load_chk: assert property (@(posedge wclk) disable iff (rst)
        (cfg_en && wr_en && wr_sel == SEL_AF) |=> (af_offset == $past(wr_low)) && $stable(ae_offset));

    // R4
    no_cfg_hold_chk: assert property (@(posedge wclk) disable iff (rst)
        !(cfg_en && wr_en) |=> $stable(ae_offset) && $stable(af_offset));

    // R6
    rd_hold_chk: assert property (@(posedge rclk) disable iff (rst)
        !(cfg_en && rd_en) |=> $stable(rd_data));

    // R9
    wsel_home_chk: assert property (@(posedge wclk) disable iff (rst)
        $fell(rst) |-> wr_sel == SEL_AE);

    // R9
    rsel_home_chk: assert property (@(posedge rclk) disable iff (rst)
        $fell(rst) |-> rd_sel == SEL_AE);

endmodule

bind ofs_loader ofs_loader_chk #(
    .DATA_W      (DATA_W),
    .OFS_W       (OFS_W),
    .OFS_DEFAULT (OFS_DEFAULT)
) chk_i (
    .wclk      (wclk),
    .rclk      (rclk),
    .rst       (rst),
    .cfg_en    (cfg_en),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_low    (wr_data[OFS_W-1:0]),
    .rd_data   (rd_data),
    .ae_offset (ae_offset),
    .af_offset (af_offset),
    .wr_sel    (wr_sel),
    .rd_sel    (rd_sel)
);

// File: tb/ofs_loader_tb_top.sv
module ofs_loader_tb_top;

    localparam int WCLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int DATA_W      = 18;
    localparam int OFS_W       = 6;
    localparam int OFS_DEFAULT = 45;

    logic              wclk = 1'b0;
    logic              rclk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_en = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [OFS_W-1:0]  ae_offset;
    logic [OFS_W-1:0]  af_offset;
    logic              fifo_wr_ok;
    logic              fifo_rd_ok;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // reference model state
    int m_ofs[2];
    int m_wp = 0;
    int m_rp = 0;
    int m_rd = 0;

    always #(WCLK_PERIOD/2) wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    ofs_loader #(
        .DATA_W      (DATA_W),
        .OFS_W       (OFS_W),
        .OFS_DEFAULT (OFS_DEFAULT)
    ) dut_i (
        .wclk       (wclk),
        .rclk       (rclk),
        .rst        (rst),
        .cfg_en     (cfg_en),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .ae_offset  (ae_offset),
        .af_offset  (af_offset),
        .fifo_wr_ok (fifo_wr_ok),
        .fifo_rd_ok (fifo_rd_ok)
    );

    task automatic check(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    always @(posedge wclk) begin
        if (rst) begin
            m_wp = 0;
            m_ofs[0] = OFS_DEFAULT;
            m_ofs[1] = OFS_DEFAULT;
        end else if (cfg_en && wr_en) begin
            m_ofs[m_wp] = int'(wr_data) % (1 << OFS_W);
            m_wp = 1 - m_wp;
        end
        #2;
        check("ae_offset", int'(ae_offset), m_ofs[0]);
        check("af_offset", int'(af_offset), m_ofs[1]);
        check("fifo_wr_ok", int'(fifo_wr_ok), int'(wr_en && !cfg_en));
    end

    always @(posedge rclk) begin
        if (rst) begin
            m_rp = 0;
            m_rd = 0;
        end else if (cfg_en && rd_en) begin
            m_rd = m_ofs[m_rp];
            m_rp = 1 - m_rp;
        end
        #2;
        check("rd_data", int'(rd_data), m_rd);
        check("fifo_rd_ok", int'(fifo_rd_ok), int'(rd_en && !cfg_en));
    end

    task automatic wcyc(bit c, bit w, int d);
        @(negedge wclk);
        cfg_en  = c;
        wr_en   = w;
        wr_data = DATA_W'(d);
    endtask

    task automatic rcyc(bit c, bit r);
        @(negedge rclk);
        cfg_en = c;
        rd_en  = r;
    endtask

    task automatic widle(int n);
        for (int i = 0; i < n; i++) wcyc(1'b0, 1'b0, 0);
    endtask

    task automatic ridle(int n);
        for (int i = 0; i < n; i++) rcyc(1'b0, 1'b0);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        widle(5);
        @(negedge wclk) rst = 1'b0;
        widle(4);
        check("R1 direct ae", int'(ae_offset), OFS_DEFAULT);
        check("R1 direct rd_data", int'(rd_data), 0);

        // R4 and R8: plain data write, then strobe alone
        tag = "R4";
        wcyc(1'b0, 1'b1, 'h3FFFF);
        wcyc(1'b0, 1'b1, 'h2AAAA);
        wcyc(1'b1, 1'b0, 'h3FFFF);
        wcyc(1'b1, 1'b0, 'h11111);
        widle(2);
        check("R4 ae untouched", int'(ae_offset), OFS_DEFAULT);
        check("R4 af untouched", int'(af_offset), OFS_DEFAULT);

        // R2: first configuration write goes to almost-empty
        tag = "R2";
        wcyc(1'b1, 1'b1, 'h3F00A);
        widle(2);
        check("R2 ae loaded", int'(ae_offset), 'h0A);

        // R3: alternation af then ae
        tag = "R3";
        wcyc(1'b1, 1'b1, 'h20015);
        wcyc(1'b1, 1'b1, 'h1FF2C);
        widle(2);
        check("R3 af loaded", int'(af_offset), 'h15);
        check("R3 ae reloaded", int'(ae_offset), 'h2C);

        // R5: new session continues with af
        tag = "R5";
        wcyc(1'b1, 1'b1, 'h00033);
        widle(1);
        wcyc(1'b1, 1'b1, 'h10007);
        widle(2);
        check("R5 af next", int'(af_offset), 'h33);
        check("R5 ae after", int'(ae_offset), 'h07);

        // R8: configuration cycle masks data write
        tag = "R8";
        wcyc(1'b1, 1'b1, 'h0001E);
        widle(2);

        // R6: readback order ae, af, ae
        tag = "R6";
        rcyc(1'b1, 1'b1);
        rcyc(1'b1, 1'b1);
        rcyc(1'b1, 1'b1);
        rcyc(1'b0, 1'b1);
        rcyc(1'b1, 1'b0);
        ridle(2);
        check("R6 last readback", int'(rd_data), m_ofs[0]);
        check("R6 upper bits", int'(rd_data[DATA_W-1:OFS_W]), 0);

        // R7: more writes, read selector stays on af
        tag = "R7";
        widle(1);
        wcyc(1'b1, 1'b1, 'h00009);
        widle(2);
        rcyc(1'b1, 1'b1);
        ridle(2);
        check("R7 read af", int'(rd_data), int'(af_offset));

        // R9: reset mid-sequence returns both selectors home
        tag = "R9";
        widle(1);
        wcyc(1'b1, 1'b1, 'h00021);
        @(negedge wclk) rst = 1'b1;
        widle(4);
        @(negedge wclk) rst = 1'b0;
        widle(2);
        wcyc(1'b1, 1'b1, 'h3003C);
        widle(2);
        check("R9 ae after reset", int'(ae_offset), 'h3C);
        check("R9 af default", int'(af_offset), OFS_DEFAULT);
        rcyc(1'b1, 1'b1);
        ridle(2);
        check("R9 readback ae", int'(rd_data), 'h3C);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(WCLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL %s watchdog act=running exp=finished", tag);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule